// File: doc/BRIEF.md
# I2C SCL Speed-Mode Timing Generator

This block produces the SCL waveform of an I2C bus master from programmable high-phase and low-phase cycle counts. It holds three independent count pairs: one for standard mode, one for fast mode (fast-mode-plus reuses this pair with smaller values), and one for high-speed mode. A 2-bit speed field picks the active pair. When the build parameter says high speed is not available, a high-speed request runs on the fast-mode pair.

Alongside SCL it pulses an SDA change strobe a programmable number of cycles after every SCL falling edge. The data shifter uses this strobe to move SDA only after a hold delay. The hold delay is clipped so that the strobe always lands inside the same low phase. The count and hold inputs must only be changed while `enable` is low.

The state machine has three states. IDLE releases SCL and has the count at zero. HIGH_PH drives SCL high. LOW_PH drives SCL low. The transitions are:
- start: IDLE to HIGH_PH, when `enable` is high.
- high_done: HIGH_PH to LOW_PH, after the high count.
- low_done: LOW_PH to HIGH_PH, after the low count.
- stop: any state to IDLE, when `enable` is low.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is asserted and after its release with `enable` low, `scl_out` is 1 and `sda_strobe` is 0.
- R2: Speed code 2'b01 selects the standard pair (`std_hi`, `std_lo`).
- R3: Speed codes 2'b10 and 2'b00 select the fast pair (`fast_hi`, `fast_lo`).
- R4: Speed code 2'b11 selects the high-speed pair (`hs_hi`, `hs_lo`) when HS_EN is 1.
- R5: When HS_EN is 0, speed code 2'b11 behaves exactly as fast mode.
- R6: While enabled, SCL stays high for exactly the selected high count and low for exactly the selected low count, in cycles.
- R7: A high or low count of 0 is treated as 1.
- R8: `sda_strobe` pulses for one cycle in each low phase, exactly `sda_hold` cycles after the cycle in which SCL went low. A hold of 0 pulses in that first low cycle.
- R9: The hold delay saturates at low count minus 1, so the strobe is in the last low cycle when `sda_hold` is too large.
- R10: One clock edge after `enable` is sampled low, SCL is 1 and the count is cleared. On re-enable, a full high phase of the selected length comes first.
- R11: `sda_strobe` is never asserted while `scl_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the generator; low releases SCL |
| speed_sel | input | 2 | 01 standard, 10/00 fast, 11 high speed |
| std_hi | input | CNT_W | Standard-mode high count |
| std_lo | input | CNT_W | Standard-mode low count |
| fast_hi | input | CNT_W | Fast-mode high count |
| fast_lo | input | CNT_W | Fast-mode low count |
| hs_hi | input | CNT_W | High-speed high count |
| hs_lo | input | CNT_W | High-speed low count |
| sda_hold | input | CNT_W | Cycles from SCL fall to the SDA strobe |
| scl_out | output | 1 | SCL level to drive (1 = released) |
| sda_strobe | output | 1 | One-cycle SDA change strobe |

## Verification
Both outputs come straight from the state and count registers. They therefore change one clock edge after the edge that moves the state, and one edge after `enable` is sampled. The bench drives inputs and samples outputs on falling clock edges, so each sample sees exactly one clock cycle. A high or low phase of N cycles then appears as N consecutive equal samples. The strobe position is counted from the first low sample, which makes a hold of h show up at sample index h. The first full high phase after re-enable is counted from the first rising edge after `enable` is set.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HIGH_PH = 2'd1,
        ST_LOW_PH  = 2'd2
    } scl_state_e;

    localparam logic [1:0] SPD_STD  = 2'b01;
    localparam logic [1:0] SPD_FAST = 2'b10;
    localparam logic [1:0] SPD_HS   = 2'b11;

endpackage

// File: rtl/scl_tg_sel.sv
module scl_tg_sel #(
    parameter int CNT_W = 16,
    parameter bit HS_EN = 1'b1
) (
    input  logic [1:0]       speed_sel,
    input  logic [CNT_W-1:0] std_hi,
    input  logic [CNT_W-1:0] std_lo,
    input  logic [CNT_W-1:0] fast_hi,
    input  logic [CNT_W-1:0] fast_lo,
    input  logic [CNT_W-1:0] hs_hi,
    input  logic [CNT_W-1:0] hs_lo,
    input  logic [CNT_W-1:0] sda_hold,
    output logic [CNT_W-1:0] hi_eff,
    output logic [CNT_W-1:0] lo_eff,
    output logic [CNT_W-1:0] hold_eff
);
    import scl_tg_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             use_hs;
    logic [CNT_W-1:0] raw_hi;
    logic [CNT_W-1:0] raw_lo;
    logic [CNT_W-1:0] lo_last;

    // High-speed decode exists only when the build supports it.
    generate
        if (HS_EN) begin : g_hs
            assign use_hs = (speed_sel == SPD_HS);
        end else begin : g_no_hs
            assign use_hs = 1'b0;
        end
    endgenerate

    always_comb begin
        if (use_hs) begin
            raw_hi = hs_hi;
            raw_lo = hs_lo;
        end else if (speed_sel == SPD_STD) begin
            raw_hi = std_hi;
            raw_lo = std_lo;
        end else begin
            raw_hi = fast_hi;
            raw_lo = fast_lo;
        end
    end

    // A count of 0 is treated as 1.
    assign hi_eff  = (raw_hi == '0) ? ONE : raw_hi;
    assign lo_eff  = (raw_lo == '0) ? ONE : raw_lo;
    assign lo_last = lo_eff - ONE;
    assign hold_eff = (sda_hold > lo_last) ? lo_last : sda_hold;

endmodule

// File: rtl/scl_tg_fsm.sv
module scl_tg_fsm #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] hi_eff,
    input  logic [CNT_W-1:0] lo_eff,
    output logic             scl_level,
    output logic             in_low,
    output logic [CNT_W-1:0] phase_cnt
);
    import scl_tg_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    scl_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + ONE;
        if (!enable) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_HIGH_PH;
                    cnt_d   = '0;
                end
                ST_HIGH_PH: begin
                    if (cnt_q >= hi_eff - ONE) begin
                        state_d = ST_LOW_PH;
                        cnt_d   = '0;
                    end
                end
                ST_LOW_PH: begin
                    if (cnt_q >= lo_eff - ONE) begin
                        state_d = ST_HIGH_PH;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        scl_level = (state_q != ST_LOW_PH);
        in_low    = (state_q == ST_LOW_PH);
        phase_cnt = cnt_q;
    end

endmodule

// File: rtl/scl_tg_strobe.sv
module scl_tg_strobe #(
    parameter int CNT_W = 16
) (
    input  logic             in_low,
    input  logic [CNT_W-1:0] phase_cnt,
    input  logic [CNT_W-1:0] hold_eff,
    output logic             strobe
);
    // Low-phase cycle index 0 is the cycle in which SCL went low.
    assign strobe = in_low && (phase_cnt == hold_eff);
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
    parameter int CNT_W = 16,
    parameter bit HS_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       speed_sel,
    input  logic [CNT_W-1:0] std_hi,
    input  logic [CNT_W-1:0] std_lo,
    input  logic [CNT_W-1:0] fast_hi,
    input  logic [CNT_W-1:0] fast_lo,
    input  logic [CNT_W-1:0] hs_hi,
    input  logic [CNT_W-1:0] hs_lo,
    input  logic [CNT_W-1:0] sda_hold,
    output logic             scl_out,
    output logic             sda_strobe
);
    logic [CNT_W-1:0] hi_eff, lo_eff, hold_eff, phase_cnt;
    logic             in_low;

    scl_tg_sel #(.CNT_W(CNT_W), .HS_EN(HS_EN)) u_sel (
        .speed_sel (speed_sel),
        .std_hi    (std_hi),
        .std_lo    (std_lo),
        .fast_hi   (fast_hi),
        .fast_lo   (fast_lo),
        .hs_hi     (hs_hi),
        .hs_lo     (hs_lo),
        .sda_hold  (sda_hold),
        .hi_eff    (hi_eff),
        .lo_eff    (lo_eff),
        .hold_eff  (hold_eff)
    );

    scl_tg_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .hi_eff    (hi_eff),
        .lo_eff    (lo_eff),
        .scl_level (scl_out),
        .in_low    (in_low),
        .phase_cnt (phase_cnt)
    );

    scl_tg_strobe #(.CNT_W(CNT_W)) u_stb (
        .in_low    (in_low),
        .phase_cnt (phase_cnt),
        .hold_eff  (hold_eff),
        .strobe    (sda_strobe)
    );

endmodule

// File: rtl/scl_tg_checker.sv
module scl_tg_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic [CNT_W-1:0] sda_hold,
    input logic             scl_out,
    input logic             sda_strobe
);
    // R11: the strobe only appears while SCL is low.
    assert_strobe_in_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sda_strobe |-> !scl_out);

    // R10: SCL is released one edge after enable is sampled low.
    assert_release_on_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_out && !sda_strobe));

    // R8: at most one strobe per low phase, so it never lasts two cycles.
    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sda_strobe |=> !sda_strobe);

    // R8: with a hold of zero, the strobe coincides with the SCL fall.
    assert_zero_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_out) && sda_hold == '0) |-> sda_strobe);

    // R1: the output is released during reset.
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_idle_R1: assert (scl_out && !sda_strobe);
        end
    end
endmodule

bind scl_timing_gen scl_tg_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .sda_hold   (sda_hold),
    .scl_out    (scl_out),
    .sda_strobe (sda_strobe)
);

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [1:0]    speed_sel = 2'b01;
    logic [CW-1:0] std_hi = 16'd5, std_lo = 16'd7;
    logic [CW-1:0] fast_hi = 16'd3, fast_lo = 16'd4;
    logic [CW-1:0] hs_hi = 16'd2, hs_lo = 16'd2;
    logic [CW-1:0] sda_hold = '0;
    logic          scl_a, stb_a, scl_b, stb_b;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    scl_timing_gen #(.CNT_W(CW), .HS_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .speed_sel(speed_sel),
        .std_hi(std_hi), .std_lo(std_lo), .fast_hi(fast_hi), .fast_lo(fast_lo),
        .hs_hi(hs_hi), .hs_lo(hs_lo), .sda_hold(sda_hold),
        .scl_out(scl_a), .sda_strobe(stb_a));

    scl_timing_gen #(.CNT_W(CW), .HS_EN(1'b0)) u_dut_nohs (
        .clk(clk), .rst_n(rst_n), .enable(enable), .speed_sel(speed_sel),
        .std_hi(std_hi), .std_lo(std_lo), .fast_hi(fast_hi), .fast_lo(fast_lo),
        .hs_hi(hs_hi), .hs_lo(hs_lo), .sda_hold(sda_hold),
        .scl_out(scl_b), .sda_strobe(stb_b));

    // Vector table: speed code, hold, expected high, low, strobe offset (u_dut).
    localparam int NV = 6;
    localparam int V_SPD [NV] = '{1, 2, 0, 3, 2, 1};
    localparam int V_HLD [NV] = '{2, 1, 0, 1, 6, 9};
    localparam int V_HI  [NV] = '{5, 3, 3, 2, 3, 5};
    localparam int V_LO  [NV] = '{7, 4, 4, 2, 4, 7};
    localparam int V_OFF [NV] = '{2, 1, 0, 1, 3, 6};

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic rd_scl(input bit b);
        return b ? scl_b : scl_a;
    endfunction

    function automatic logic rd_stb(input bit b);
        return b ? stb_b : stb_a;
    endfunction

    // Restart the generator with new settings, clearing it first.
    task automatic restart(input int spd, input int hold);
        enable = 1'b0;
        @(negedge clk);
        check("R10 released after disable", int'(scl_a), 1);
        @(negedge clk);
        speed_sel = 2'(spd);
        sda_hold  = CW'(hold);
        enable    = 1'b1;
    endtask

    // Measure one full low phase and the following high phase.
    task automatic measure(input string req, input bit b,
                           input int e_hi, input int e_lo, input int e_off);
        int lo_n = 0, hi_n = 0, pos = -1, nstb = 0, hi_stb = 0, guard = 0;
        while (rd_scl(b) != 1'b1 && guard < 200) begin @(negedge clk); guard++; end
        while (rd_scl(b) != 1'b0 && guard < 200) begin @(negedge clk); guard++; end
        while (rd_scl(b) == 1'b0 && guard < 200) begin
            if (rd_stb(b)) begin pos = lo_n; nstb++; end
            lo_n++; guard++;
            @(negedge clk);
        end
        while (rd_scl(b) == 1'b1 && guard < 200) begin
            if (rd_stb(b)) hi_stb++;
            hi_n++; guard++;
            @(negedge clk);
        end
        check({req, " R6 low length"}, lo_n, e_lo);
        check({req, " R6 high length"}, hi_n, e_hi);
        check({req, " R8 strobe offset"}, pos, e_off);
        check({req, " R8 strobe count"}, nstb, 1);
        check({req, " R11 strobe while high"}, hi_stb, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 scl in reset", int'(scl_a), 1);
        check("R1 strobe in reset", int'(stb_a), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 scl idle after reset", int'(scl_a), 1);
        check("R1 strobe idle after reset", int'(stb_a), 0);

        // Table walk: R2 (v0), R3 (v1, v2), R4 (v3), R9 (v4, v5)
        for (int i = 0; i < NV; i++) begin
            restart(V_SPD[i], V_HLD[i]);
            measure($sformatf("vec%0d R2/R3/R4/R9", i), 1'b0, V_HI[i], V_LO[i], V_OFF[i]);
        end

        // R5: high-speed request without support runs on the fast pair
        restart(3, 1);
        measure("R5 fallback", 1'b1, 3, 4, 1);

        // R7: zero counts act as one
        std_hi = '0; std_lo = '0;
        restart(1, 0);
        measure("R7 zero counts", 1'b0, 1, 1, 0);
        std_hi = 16'd5; std_lo = 16'd7;

        // R10: after re-enable, the first high phase is full length
        begin
            int hn = 0;
            restart(1, 2);
            @(negedge clk);
            while (scl_a == 1'b1 && hn < 50) begin hn++; @(negedge clk); end
            check("R10 first high phase after enable", hn, 5);
        end

        // R10: SCL stays released while disabled
        enable = 1'b0;
        begin
            int lows = 0;
            @(negedge clk);
            for (int k = 0; k < 10; k++) begin
                if (scl_a == 1'b0 || stb_a) lows++;
                @(negedge clk);
            end
            check("R10 idle while disabled", lows, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule